// File: doc/BRIEF.md
# Read Gate and Per-Bit Deskew Trainer

This block trains the read path of a byte lane in two phases. In the first phase it issues one read command and watches the sampled strobe for the preamble. The preamble is a fixed number of low-to-high strobe transitions. The cycle offset of the first transition becomes the gate latency, which sets when the strobe gate opens on later reads. Gate training always completes before per-bit deskew starts.

In the second phase the trainer sweeps every tap of the per-bit sampling delay. It issues one read per tap and moves all bits to that tap together. It compares each data bit against a known pattern, but only while the gate is open. For each bit it tracks the longest run of consecutive passing taps and then programs that bit to the middle of its own run. The delay cells and the memory sit outside the block. The trainer only drives delay codes and reads back sampled data.

The controller is a state machine with these states:
- `ST_IDLE` waits for start. `ST_IDLE -> ST_GATE_REQ` on start.
- `ST_GATE_REQ` issues the gate read. `ST_GATE_REQ -> ST_GATE_WAIT`.
- `ST_GATE_WAIT` counts cycles and strobe edges. It goes to `ST_SWEEP_REQ` when the preamble completes, or to `ST_DONE` on timeout.
- `ST_SWEEP_REQ` issues one sweep read. `ST_SWEEP_REQ -> ST_SWEEP_RX`.
- `ST_SWEEP_RX` compares data while the gate is open. `ST_SWEEP_RX -> ST_SWEEP_STEP` after the last beat.
- `ST_SWEEP_STEP` records pass or fail for the tap. It returns to `ST_SWEEP_REQ`, or goes to `ST_CENTER` after the last tap.
- `ST_CENTER` computes each bit's midpoint. `ST_CENTER -> ST_DONE`.
- `ST_DONE` holds the results. `ST_DONE -> ST_GATE_REQ` on a new start.

Top module: `rd_train_ctrl`

## Requirements
- R1: After reset the outputs are as follows: `done_o`, `rd_req_o` and `gate_o` are low, `gate_lat_o` is 0, all flags are clear, and every delay slice equals DEF_TAP.
- R2: A start pulse accepted in idle or done begins a new run and clears earlier results. Every read request is a single-cycle pulse. A successful run issues exactly 1 + 2^TAPW reads.
- R3: A strobe rising edge is a sample of 1 whose previous sample in the same wait was 0. Offset m is the m-th clock edge after the edge that samples the read request. The gate latency is the offset of the first rising edge, and gate training succeeds once PRE_EDGES rising edges are seen.
- R4: If the PRE_EDGES-th edge has not arrived by offset MAX_LAT, the run ends with `gate_fail_o` set and `gate_lat_o` at 0. No sweep reads are issued and all delays stay at DEF_TAP.
- R5: Sweep reads step tap t from 0 to 2^TAPW-1 in ascending order. While a sweep read is in flight, every delay slice shows t.
- R6: On each sweep read, `gate_o` is high for exactly BURST consecutive cycles, starting at offset equal to the learned latency. At beat b (0 from gate open), data bit i is expected to equal b[0]^i[0]^(b[1]&i[1]).
- R7: A tap passes for a bit when all BURST beats match. The chosen delay is s+floor((n-1)/2), where s is the start and n the length of the longest run of passing taps. On a tie, the run that starts first wins.
- R8: A bit with no passing tap gets its bit in `bit_fail_o` set, and its delay slice stays at DEF_TAP.
- R9: `done_o` rises at the end of a run. It stays high with delays and latency unchanged, and with no reads and no gate, until the next start.
- R10: Data sampled while the gate is closed has no effect on the trained delays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse to begin training |
| done_o | output | 1 | Training finished; results valid |
| rd_req_o | output | 1 | Read command request pulse |
| strb_i | input | 1 | Strobe sampled in the clock domain |
| dq_i | input | NBITS | Data bits sampled in the clock domain |
| gate_o | output | 1 | Strobe gate open; data is compared |
| gate_lat_o | output | $clog2(MAX_LAT+1) | Learned gate latency in cycles |
| dly_o | output | NBITS*TAPW | Per-bit sampling delay codes, bit i at [i*TAPW +: TAPW] |
| gate_fail_o | output | 1 | Preamble not found within MAX_LAT |
| bit_fail_o | output | NBITS | Per-bit flag: no passing tap |

## Verification
The bench builds the trainer with these parameters:

| Parameter | Bench value | Tap count or limit |
|---|---|---|
| NBITS | 4 | 4 bits |
| TAPW | 4 | 16 taps |
| MAX_LAT | 12 | latency limit 12 |
| PRE_EDGES | 2 | two preamble edges |
| BURST | 4 | four-beat bursts |
| DEF_TAP | 8 | default delay 8 |

With only 16 taps, a single mask per bit can place a pass window at tap 0, at the last tap, across all taps, as a single tap, as two runs of different length, or as two runs of equal length. The latency limit of 12 lets one latency end the preamble exactly on the limit (pass) and the next latency end it one cycle past the limit (fail). A run with no strobe at all is also covered. Data outside the gate window is always driven wrong, so any comparison outside the window shows up in the trained results.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GATE_REQ,
        ST_GATE_WAIT,
        ST_SWEEP_REQ,
        ST_SWEEP_RX,
        ST_SWEEP_STEP,
        ST_CENTER,
        ST_DONE
    } rdt_state_e;

    // Known training pattern: expected value of data bit `lane` at burst beat `beat`.
    function automatic logic ref_bit(input logic [7:0] beat, input logic [7:0] lane);
        return beat[0] ^ lane[0] ^ (beat[1] & lane[1]);
    endfunction

endpackage

// File: rtl/rdt_preamble_det.sv
module rdt_preamble_det #(
    parameter int PRE_EDGES = 2,
    parameter int CW        = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          en_i,
    input  logic          strb_i,
    input  logic [CW-1:0] offs_i,
    output logic          hit_o,
    output logic [CW-1:0] lat_o
);
    localparam int EW = $clog2(PRE_EDGES + 1);

    logic          prev_q;
    logic [EW-1:0] edges_q;
    logic [CW-1:0] first_q;
    logic          rise;

    assign rise = en_i && strb_i && !prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            edges_q <= '0;
            first_q <= '0;
        end else if (clr_i) begin
            prev_q  <= 1'b0;
            edges_q <= '0;
            first_q <= '0;
        end else if (en_i) begin
            prev_q <= strb_i;
            if (rise) begin
                edges_q <= edges_q + EW'(1);
                if (edges_q == '0) begin
                    first_q <= offs_i;
                end
            end
        end
    end

    // Final preamble edge arrives this cycle.
    assign hit_o = rise && (edges_q == EW'(PRE_EDGES - 1));
    // Latency is the offset of the first edge (possibly this one).
    assign lat_o = (edges_q == '0) ? offs_i : first_q;

endmodule

// File: rtl/rdt_bit_lane.sv
module rdt_bit_lane #(
    parameter int TAPW    = 5,
    parameter int CW      = 5,
    parameter int LANE    = 0,
    parameter int DEF_TAP = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            smp_i,
    input  logic [CW-1:0]   beat_i,
    input  logic            dq_i,
    input  logic [TAPW-1:0] tap_i,
    input  logic            commit_i,
    input  logic            final_i,
    output logic [TAPW-1:0] dly_o,
    output logic            fail_o
);
    localparam int        LW      = TAPW + 1;
    localparam logic [7:0] LANE_ID = 8'(LANE);

    logic            acc_q;
    logic [TAPW-1:0] cur_s_q, best_s_q;
    logic [LW-1:0]   cur_l_q, best_l_q;
    logic [TAPW-1:0] dly_q;
    logic            fail_q;

    logic            exp_b;
    logic [LW-1:0]   run_len;
    logic [TAPW-1:0] run_start;
    logic [TAPW-1:0] mid_tap;

    assign exp_b     = rdt_pkg::ref_bit(8'(beat_i), LANE_ID);
    assign run_len   = cur_l_q + LW'(1);
    assign run_start = (cur_l_q == '0) ? tap_i : cur_s_q;
    assign mid_tap   = best_s_q + TAPW'((best_l_q - LW'(1)) >> 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q    <= 1'b1;
            cur_s_q  <= '0;
            cur_l_q  <= '0;
            best_s_q <= '0;
            best_l_q <= '0;
            dly_q    <= TAPW'(DEF_TAP);
            fail_q   <= 1'b0;
        end else if (clr_i) begin
            acc_q    <= 1'b1;
            cur_s_q  <= '0;
            cur_l_q  <= '0;
            best_s_q <= '0;
            best_l_q <= '0;
            dly_q    <= TAPW'(DEF_TAP);
            fail_q   <= 1'b0;
        end else begin
            if (commit_i) begin
                acc_q <= 1'b1;
                if (acc_q) begin
                    cur_l_q <= run_len;
                    cur_s_q <= run_start;
                    if (run_len > best_l_q) begin
                        best_l_q <= run_len;
                        best_s_q <= run_start;
                    end
                end else begin
                    cur_l_q <= '0;
                end
            end else if (smp_i) begin
                acc_q <= acc_q & (dq_i == exp_b);
            end
            if (final_i) begin
                if (best_l_q == '0) begin
                    fail_q <= 1'b1;
                    dly_q  <= TAPW'(DEF_TAP);
                end else begin
                    dly_q  <= mid_tap;
                end
            end
        end
    end

    assign dly_o  = dly_q;
    assign fail_o = fail_q;

endmodule

// File: rtl/rd_train_ctrl.sv
module rd_train_ctrl #(
    parameter int NBITS     = 8,
    parameter int TAPW      = 5,
    parameter int MAX_LAT   = 20,
    parameter int PRE_EDGES = 2,
    parameter int BURST     = 8,
    parameter int DEF_TAP   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    output logic                         done_o,
    output logic                         rd_req_o,
    input  logic                         strb_i,
    input  logic [NBITS-1:0]             dq_i,
    output logic                         gate_o,
    output logic [$clog2(MAX_LAT+1)-1:0] gate_lat_o,
    output logic [NBITS*TAPW-1:0]        dly_o,
    output logic                         gate_fail_o,
    output logic [NBITS-1:0]             bit_fail_o
);
    import rdt_pkg::*;

    localparam int NTAPS = 1 << TAPW;
    localparam int CW    = $clog2(MAX_LAT + BURST + 2);
    localparam int LATW  = $clog2(MAX_LAT + 1);

    rdt_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q;
    logic [TAPW-1:0] tap_q;
    logic [LATW-1:0] lat_q;
    logic            gfail_q;

    logic            start_go;
    logic            det_hit;
    logic [CW-1:0]   det_lat;
    logic [CW-1:0]   lat_ext;
    logic            gate_win;
    logic            last_beat;
    logic            last_tap;
    logic            sweeping;
    logic [CW-1:0]   beat;

    assign start_go  = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
    assign lat_ext   = CW'(lat_q);
    assign gate_win  = (state_q == ST_SWEEP_RX) && (cnt_q >= lat_ext)
                       && (cnt_q < lat_ext + CW'(BURST));
    assign last_beat = (state_q == ST_SWEEP_RX) && (cnt_q == lat_ext + CW'(BURST - 1));
    assign last_tap  = (tap_q == TAPW'(NTAPS - 1));
    assign beat      = cnt_q - lat_ext;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = ST_GATE_REQ;
            ST_GATE_REQ:   state_d = ST_GATE_WAIT;
            ST_GATE_WAIT: begin
                if (det_hit)                        state_d = ST_SWEEP_REQ;
                else if (cnt_q == CW'(MAX_LAT))     state_d = ST_DONE;
            end
            ST_SWEEP_REQ:  state_d = ST_SWEEP_RX;
            ST_SWEEP_RX:   if (last_beat) state_d = ST_SWEEP_STEP;
            ST_SWEEP_STEP: state_d = last_tap ? ST_CENTER : ST_SWEEP_REQ;
            ST_CENTER:     state_d = ST_DONE;
            ST_DONE:       if (start_i) state_d = ST_GATE_REQ;
            default:       state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            tap_q   <= '0;
            lat_q   <= '0;
            gfail_q <= 1'b0;
        end else begin
            if (start_go) begin
                tap_q   <= '0;
                lat_q   <= '0;
                gfail_q <= 1'b0;
            end
            unique case (state_q)
                ST_GATE_REQ, ST_SWEEP_REQ: cnt_q <= CW'(1);
                ST_GATE_WAIT: begin
                    cnt_q <= cnt_q + CW'(1);
                    if (det_hit)                    lat_q   <= LATW'(det_lat);
                    else if (cnt_q == CW'(MAX_LAT)) gfail_q <= 1'b1;
                end
                ST_SWEEP_RX:   cnt_q <= cnt_q + CW'(1);
                ST_SWEEP_STEP: tap_q <= tap_q + TAPW'(1);
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_req_o = 1'b0;
        done_o   = 1'b0;
        gate_o   = 1'b0;
        sweeping = 1'b0;
        unique case (state_q)
            ST_GATE_REQ:   rd_req_o = 1'b1;
            ST_SWEEP_REQ:  begin rd_req_o = 1'b1; sweeping = 1'b1; end
            ST_SWEEP_RX:   begin gate_o = gate_win; sweeping = 1'b1; end
            ST_SWEEP_STEP: sweeping = 1'b1;
            ST_DONE:       done_o = 1'b1;
            default: ;
        endcase
    end

    assign gate_lat_o  = lat_q;
    assign gate_fail_o = gfail_q;

    rdt_preamble_det #(
        .PRE_EDGES (PRE_EDGES),
        .CW        (CW)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (state_q == ST_GATE_REQ),
        .en_i   (state_q == ST_GATE_WAIT),
        .strb_i (strb_i),
        .offs_i (cnt_q),
        .hit_o  (det_hit),
        .lat_o  (det_lat)
    );

    for (genvar gi = 0; gi < NBITS; gi++) begin : g_lane
        logic [TAPW-1:0] lane_dly;
        rdt_bit_lane #(
            .TAPW    (TAPW),
            .CW      (CW),
            .LANE    (gi),
            .DEF_TAP (DEF_TAP)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (start_go),
            .smp_i    (gate_win),
            .beat_i   (beat),
            .dq_i     (dq_i[gi]),
            .tap_i    (tap_q),
            .commit_i (state_q == ST_SWEEP_STEP),
            .final_i  (state_q == ST_CENTER),
            .dly_o    (lane_dly),
            .fail_o   (bit_fail_o[gi])
        );
        assign dly_o[gi*TAPW +: TAPW] = sweeping ? tap_q : lane_dly;
    end

endmodule

// File: rtl/rdt_checker.sv
module rdt_checker #(
    parameter int NBITS   = 8,
    parameter int TAPW    = 5,
    parameter int MAX_LAT = 20,
    parameter int BURST   = 8,
    parameter int DEF_TAP = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start_i,
    input logic                         done_o,
    input logic                         rd_req_o,
    input logic                         gate_o,
    input logic [$clog2(MAX_LAT+1)-1:0] gate_lat_o,
    input logic [NBITS*TAPW-1:0]        dly_o,
    input logic                         gate_fail_o,
    input logic [NBITS-1:0]             bit_fail_o
);
    localparam int LATW = $clog2(MAX_LAT + 1);
    localparam int GW   = $clog2(BURST + 2);

    logic [GW-1:0] glen_q;

    // Length of the current open-gate run so far.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      glen_q <= '0;
        else if (gate_o) glen_q <= glen_q + GW'(1);
        else             glen_q <= '0;
    end

    a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);

    a_r6_gate_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> !rd_req_o);

    a_r6_gate_len: assert property (@(posedge clk) disable iff (!rst_n)
        gate_o |-> (glen_q < GW'(BURST)));

    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!rd_req_o && !gate_o));

    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(dly_o) && $stable(gate_lat_o)));

    a_r4_fail_default: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && gate_fail_o) |->
            ((dly_o == {NBITS{TAPW'(DEF_TAP)}}) && (gate_lat_o == '0)));

    a_r3_lat_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !gate_fail_o) |->
            ((gate_lat_o >= LATW'(1)) && (gate_lat_o <= LATW'(MAX_LAT))));

    for (genvar gi = 0; gi < NBITS; gi++) begin : g_bit
        a_r8_bit_default: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && bit_fail_o[gi]) |-> (dly_o[gi*TAPW +: TAPW] == TAPW'(DEF_TAP)));
    end

endmodule

bind rd_train_ctrl rdt_checker #(
    .NBITS   (NBITS),
    .TAPW    (TAPW),
    .MAX_LAT (MAX_LAT),
    .BURST   (BURST),
    .DEF_TAP (DEF_TAP)
) u_rdt_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .done_o      (done_o),
    .rd_req_o    (rd_req_o),
    .gate_o      (gate_o),
    .gate_lat_o  (gate_lat_o),
    .dly_o       (dly_o),
    .gate_fail_o (gate_fail_o),
    .bit_fail_o  (bit_fail_o)
);

// File: tb/test_rd_train_ctrl.sv
module test_rd_train_ctrl;

    localparam int NB   = 4;
    localparam int TW   = 4;
    localparam int ML   = 12;
    localparam int PE   = 2;
    localparam int BL   = 4;
    localparam int DT   = 8;
    localparam int NT   = 1 << TW;
    localparam int LATW = $clog2(ML + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start_i = 1'b0;
    logic                 done_o, rd_req_o, gate_o, gate_fail_o;
    logic                 strb_i = 1'b0;
    logic [NB-1:0]        dq_i = '0;
    logic [LATW-1:0]      gate_lat_o;
    logic [NB*TW-1:0]     dly_o;
    logic [NB-1:0]        bit_fail_o;

    always #4 clk = ~clk;

    rd_train_ctrl #(
        .NBITS(NB), .TAPW(TW), .MAX_LAT(ML), .PRE_EDGES(PE), .BURST(BL), .DEF_TAP(DT)
    ) i_rd_train_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
        .rd_req_o(rd_req_o), .strb_i(strb_i), .dq_i(dq_i), .gate_o(gate_o),
        .gate_lat_o(gate_lat_o), .dly_o(dly_o), .gate_fail_o(gate_fail_o),
        .bit_fail_o(bit_fail_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- memory and delay-cell model ----------------
    int            m_lat = 5;
    bit            m_pre = 1'b1;
    logic [NT-1:0] m_mask [NB];
    int            age = 1000;

    function automatic logic patf(input int b, input int i);
        return logic'(((b ^ i) & 1) ^ ((b >> 1) & (i >> 1) & 1));
    endfunction

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [LATW-1:0]  lat;
        logic             gf;
        logic [NB-1:0]    bf;
        logic [NB*TW-1:0] dly;
        logic [15:0]      reads;
        logic [15:0]      gates;
    } exp_t;

    exp_t exp_q[$];
    int   rd_n = 0;
    int   g_tot = 0;
    int   g_cur = 0;
    bit   done_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_req_o) age = 0;
            else if (age < 1000) age++;

            // monitor
            if (rd_req_o) begin
                if (rd_n >= 2)
                    chk(g_cur == BL, "R6", "gate cycles per read", g_cur, BL);
                rd_n++;
                g_cur = 0;
            end
            if (gate_o) begin
                if (g_cur == 0) begin
                    chk(age == m_lat, "R6", "gate open offset", age, m_lat);
                    for (int i = 0; i < NB; i++)
                        chk(int'(dly_o[i*TW +: TW]) == rd_n - 2, "R5", "sweep tap",
                            int'(dly_o[i*TW +: TW]), rd_n - 2);
                end
                g_cur++;
                g_tot++;
            end
            if (done_o && !done_prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (rd_n >= 2)
                        chk(g_cur == BL, "R6", "gate cycles last read", g_cur, BL);
                    chk(gate_lat_o == e.lat, "R3", "gate latency", gate_lat_o, e.lat);
                    chk(gate_fail_o == e.gf, "R4", "gate fail flag", gate_fail_o, e.gf);
                    chk(bit_fail_o == e.bf, "R8", "bit fail flags", bit_fail_o, e.bf);
                    for (int i = 0; i < NB; i++)
                        chk(dly_o[i*TW +: TW] == e.dly[i*TW +: TW], "R7", "trained delay",
                            dly_o[i*TW +: TW], e.dly[i*TW +: TW]);
                    chk(rd_n == int'(e.reads), "R2", "read count", rd_n, e.reads);
                    chk(g_tot == int'(e.gates), "R10", "total gate cycles", g_tot, e.gates);
                end
                rd_n = 0;
                g_tot = 0;
                g_cur = 0;
            end
            done_prev = done_o;

            // drive for the next sampling edge
            strb_i = m_pre && age >= m_lat && age < m_lat + 2*PE - 1 && ((age - m_lat) % 2 == 0);
            for (int i = 0; i < NB; i++) begin
                int  b;
                bit  inwin;
                b     = age - m_lat;
                inwin = (b >= 0) && (b < BL) && m_mask[i][dly_o[i*TW +: TW]];
                dq_i[i] = inwin ? patf(b, i) : ~patf(b, i);
            end
        end
    end

    // Driver: compute expectation from the requirements, push it, then run.
    task automatic run_train(input int lat, input bit pre,
                             input logic [NT-1:0] m0, input logic [NT-1:0] m1,
                             input logic [NT-1:0] m2, input logic [NT-1:0] m3);
        exp_t e;
        bit   ok;
        m_lat = lat; m_pre = pre;
        m_mask[0] = m0; m_mask[1] = m1; m_mask[2] = m2; m_mask[3] = m3;
        ok = pre && (lat + 2*(PE-1) <= ML);
        e = '0;
        e.gf = !ok;
        e.lat = ok ? LATW'(lat) : '0;
        e.reads = ok ? 16'(1 + NT) : 16'd1;
        e.gates = ok ? 16'(NT * BL) : 16'd0;
        for (int i = 0; i < NB; i++) begin
            int bs = 0, bl = 0, cs = 0, cl = 0, d;
            for (int t = 0; t < NT; t++) begin
                if (m_mask[i][t]) begin
                    if (cl == 0) cs = t;
                    cl++;
                    if (cl > bl) begin bl = cl; bs = cs; end
                end else cl = 0;
            end
            if (!ok || bl == 0) d = DT;
            else d = bs + (bl - 1) / 2;
            e.bf[i] = ok && (bl == 0);
            e.dly[i*TW +: TW] = TW'(d);
        end
        exp_q.push_back(e);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (!done_o) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        logic [NB*TW-1:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done_o == 1'b0, "R1", "done at reset", done_o, 0);
        chk(rd_req_o == 1'b0, "R1", "read req at reset", rd_req_o, 0);
        chk(gate_o == 1'b0, "R1", "gate at reset", gate_o, 0);
        chk(gate_lat_o == '0, "R1", "latency at reset", gate_lat_o, 0);
        chk(gate_fail_o == 1'b0 && bit_fail_o == '0, "R1", "flags at reset",
            {gate_fail_o, bit_fail_o}, 0);
        chk(dly_o == {NB{TW'(DT)}}, "R1", "delays at reset", dly_o, {NB{TW'(DT)}});
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Windows at the middle, at tap 0, at the last tap, and a bit that never passes
        run_train(5, 1'b1, 16'h03F8, 16'h000F, 16'hFC00, 16'h0000);
        // Two runs of unequal length, a tie, a single tap, all taps;
        // the preamble ends exactly on the latency limit
        run_train(10, 1'b1, 16'h07C6, 16'h00E7, 16'h8000, 16'hFFFF);

        // R9: results hold while idle in done
        held = dly_o;
        repeat (6) @(negedge clk);
        chk(done_o == 1'b1, "R9", "done held", done_o, 1);
        chk(dly_o == held, "R9", "delays held", dly_o, held);
        chk(rd_req_o == 1'b0, "R9", "no read while done", rd_req_o, 0);

        // R4: no strobe at all, then a preamble ending one cycle past the limit
        run_train(5, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        run_train(11, 1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
        // R2: a later run clears the failure
        run_train(3, 1'b1, 16'h0030, 16'h0FF0, 16'h0001, 16'hF0F0);

        chk(exp_q.size() == 0, "R9", "pending results", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule